// File: doc/BRIEF.md
# Pre/Post-Trigger Capture Sequencer

This block steers one single-shot capture of sample words into a circular sample memory. A command input starts or aborts a capture. After a start, the block writes a programmed number of samples taken before the trigger. It then keeps writing samples while it waits for a trigger. Once a trigger is accepted, it writes a programmed number of samples taken after the trigger. Finally it appends the trigger time stamp as one extra memory word and returns to idle.

The block drives a simple memory write port: strobe, word address and data. The write pointer wraps at the top of the memory. Because of that wrap, the block records the pointer at the trigger moment as a byte address, so that software can find the samples around the trigger. It also latches a trigger time stamp and a separate stop time stamp. It raises one-cycle event pulses for the accepted trigger and for the end of the capture. A busy output tells the surrounding logic when memory readout is safe, which is while the block is idle.

The states are IDLE, PRE_TRIG, WAIT_TRIG, POST_TRIG and TAG_WR. The transitions are:
- start: IDLE to PRE_TRIG.
- pre_done: PRE_TRIG to WAIT_TRIG.
- trig_accept: WAIT_TRIG to POST_TRIG.
- post_done: POST_TRIG to TAG_WR.
- tag_done: TAG_WR to IDLE.
- abort: any active state to IDLE.

Top module: `capture_sequencer`

## Requirements
- R1: After reset the block is IDLE: busy, mem_we, trig_pulse and end_pulse are 0, and trig_byte_addr, trig_stamp and stop_stamp are 0. It leaves IDLE only on a start command (cmd_valid with cmd_code 2'b01). In IDLE, samples, triggers and code 2'b11 have no effect.
- R2: Every start resets the word pointer, so the first sample of each capture is written at word address 0. In PRE_TRIG, exactly pre_count samples (cycles with sample_valid high) are written at consecutive addresses, and then the state becomes WAIT_TRIG.
- R3: trigger_in has no effect while in PRE_TRIG. This includes the cycle that writes the last pre-trigger sample.
- R4: In WAIT_TRIG every valid sample is written. A cycle with trigger_in high is accepted as the trigger, and any valid sample in that same cycle is also written. trig_pulse is high for the single cycle after the acceptance. trig_stamp holds the timestamp value present in the acceptance cycle.
- R5: trig_byte_addr holds the word address at which the acceptance-cycle sample is written (the pointer at the trigger moment), multiplied by DATA_W/8. With the default 32-bit words this is the word address shifted left by 2.
- R6: In POST_TRIG exactly post_count samples are written. The next cycle (TAG_WR) writes trig_stamp, zero-extended, at the following word address and ignores sample_valid. end_pulse is high for the single cycle after that write, and the state is then IDLE.
- R7: The word pointer wraps from 2**ADDR_W-1 to 0 and overwrites older words.
- R8: A stop command (cmd_valid with cmd_code 2'b10) loads stop_stamp with the current timestamp. In any active state it also returns the block to IDLE on the next cycle, and it suppresses the write, trigger acceptance and tag write of that cycle. Without a stop, stop_stamp keeps its value.
- R9: busy is high exactly while the state is not IDLE, and no memory write occurs while busy is low. A start command while busy has no effect.
- R10: A pre_count of 0 makes PRE_TRIG last one cycle with no write. A post_count of 0 makes POST_TRIG last one cycle with no write before TAG_WR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 2 | 01 start, 10 stop, others no effect |
| pre_count | input | CNT_W | Number of samples to write before the trigger |
| post_count | input | CNT_W | Number of samples to write after the trigger |
| sample_valid | input | 1 | sample_data is valid this cycle |
| sample_data | input | DATA_W | Sample word |
| trigger_in | input | 1 | Trigger request (level per cycle) |
| timestamp | input | TS_W | Free-running time count |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| trig_byte_addr | output | ADDR_W+log2(DATA_W/8) | Byte address of the pointer at the trigger |
| trig_stamp | output | TS_W | Timestamp at trigger acceptance |
| stop_stamp | output | TS_W | Timestamp at the last stop command |
| trig_pulse | output | 1 | One-cycle pulse after trigger acceptance |
| end_pulse | output | 1 | One-cycle pulse after the tag word is written |
| busy | output | 1 | Capture in progress |

## Verification
Two collisions get the most attention: a trigger in the same cycle as the last pre-trigger sample, and a stop command in the same cycle as an accepted trigger.

The bench drives both deliberately. In the first collision it holds trigger_in high through every pre-trigger cycle. It then expects the write sequence to continue as a WAIT_TRIG run with no trig_pulse. In the second it raises stop, trigger and sample_valid together in WAIT_TRIG. It then expects no write, no trig_pulse, an unchanged trig_byte_addr, busy low on the next cycle and stop_stamp equal to that cycle's timestamp.

A stop during POST_TRIG is judged the same way: no tag word and no end_pulse.

// File: rtl/capseq_pkg.sv
package capseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_PRE  = 3'd1,
        S_WAIT = 3'd2,
        S_POST = 3'd3,
        S_TAG  = 3'd4
    } cap_state_t;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'b00,
        CMD_START = 2'b01,
        CMD_STOP  = 2'b10,
        CMD_RSVD  = 2'b11
    } cap_cmd_t;

endpackage

// File: rtl/capseq_count.sv
// Phase sample counter: counts written samples against a programmed limit.
module capseq_count #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic             zero,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_nx;

    always_comb begin
        cnt_nx = {1'b0, cnt_q} + 1'b1;
        zero   = (limit == '0);
        last   = zero || (inc && (cnt_nx >= {1'b0, limit}));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_nx[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/capseq_wptr.sv
// Circular word pointer with trigger-moment capture as a byte address.
module capseq_wptr #(
    parameter int ADDR_W = 5,
    parameter int BSH    = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  adv,
    input  logic                  take,
    output logic [ADDR_W-1:0]     wptr,
    output logic [ADDR_W+BSH-1:0] trig_baddr
);
    logic [ADDR_W-1:0] trig_word_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr        <= '0;
            trig_word_q <= '0;
        end else begin
            if (clr) begin
                wptr <= '0;
            end else if (adv) begin
                wptr <= wptr + 1'b1;
            end
            if (take) begin
                trig_word_q <= wptr;
            end
        end
    end

    generate
        if (BSH == 0) begin : g_word
            assign trig_baddr = trig_word_q;
        end else begin : g_byte
            assign trig_baddr = {trig_word_q, {BSH{1'b0}}};
        end
    endgenerate

    // R7: top of memory wraps to word zero
    a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && wptr == {ADDR_W{1'b1}}) |=> (wptr == '0));

    // R2: a new capture starts at word zero
    a_r2_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (wptr == '0));
endmodule

// File: rtl/capseq_fsm.sv
// Capture sequencing state machine.
module capseq_fsm
    import capseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_code,
    input  logic       sample_valid,
    input  logic       trigger_in,
    input  logic       cnt_zero,
    input  logic       cnt_last,
    output cap_state_t state_q,
    output logic       samp_we,
    output logic       tag_we,
    output logic       trig_take,
    output logic       stop_take,
    output logic       cnt_inc,
    output logic       cnt_clr,
    output logic       ptr_clr,
    output logic       trig_pulse,
    output logic       end_pulse
);
    cap_state_t state_d;
    logic       start_cmd;
    logic       counting;

    assign start_cmd = cmd_valid && (cmd_code == CMD_START);
    assign stop_take = cmd_valid && (cmd_code == CMD_STOP);
    assign counting  = (state_q == S_PRE) || (state_q == S_POST);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start_cmd) state_d = S_PRE;
            S_PRE: begin
                if (stop_take)     state_d = S_IDLE;
                else if (cnt_last) state_d = S_WAIT;
            end
            S_WAIT: begin
                if (stop_take)       state_d = S_IDLE;
                else if (trigger_in) state_d = S_POST;
            end
            S_POST: begin
                if (stop_take)     state_d = S_IDLE;
                else if (cnt_last) state_d = S_TAG;
            end
            S_TAG:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // datapath strobes
    always_comb begin
        samp_we   = sample_valid && !stop_take &&
                    ((state_q == S_WAIT) || (counting && !cnt_zero));
        tag_we    = (state_q == S_TAG) && !stop_take;
        trig_take = (state_q == S_WAIT) && !stop_take && trigger_in;
        cnt_inc   = samp_we && counting;
        cnt_clr   = (state_d != state_q);
        ptr_clr   = (state_q == S_IDLE) && start_cmd;
    end

    // event pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_pulse <= 1'b0;
            end_pulse  <= 1'b0;
        end else begin
            trig_pulse <= trig_take;
            end_pulse  <= tag_we;
        end
    end

    // R1: idle is left only on start
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !start_cmd) |=> (state_q == S_IDLE));

    // R3: a trigger pulse only follows a waiting cycle
    a_r3_trig_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> ($past(state_q) == S_WAIT));

    // R6: tag write lasts one cycle, then idle
    a_r6_tag_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TAG) |=> (state_q == S_IDLE && end_pulse == !$past(stop_take)));
endmodule

// File: rtl/capture_sequencer.sv
module capture_sequencer
    import capseq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 12,
    parameter int TS_W   = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cmd_valid,
    input  logic [1:0]                        cmd_code,
    input  logic [CNT_W-1:0]                  pre_count,
    input  logic [CNT_W-1:0]                  post_count,
    input  logic                              sample_valid,
    input  logic [DATA_W-1:0]                 sample_data,
    input  logic                              trigger_in,
    input  logic [TS_W-1:0]                   timestamp,
    output logic                              mem_we,
    output logic [ADDR_W-1:0]                 mem_addr,
    output logic [DATA_W-1:0]                 mem_wdata,
    output logic [ADDR_W+$clog2(DATA_W/8)-1:0] trig_byte_addr,
    output logic [TS_W-1:0]                   trig_stamp,
    output logic [TS_W-1:0]                   stop_stamp,
    output logic                              trig_pulse,
    output logic                              end_pulse,
    output logic                              busy
);
    localparam int BSH = $clog2(DATA_W / 8);

    cap_state_t       state;
    logic             samp_we, tag_we, trig_take, stop_take;
    logic             cnt_inc, cnt_clr, ptr_clr, cnt_zero, cnt_last;
    logic [CNT_W-1:0] limit;
    logic [DATA_W-1:0] tag_word;

    assign limit = (state == S_POST) ? post_count : pre_count;

    capseq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .sample_valid(sample_valid), .trigger_in(trigger_in),
        .cnt_zero(cnt_zero), .cnt_last(cnt_last),
        .state_q(state),
        .samp_we(samp_we), .tag_we(tag_we), .trig_take(trig_take),
        .stop_take(stop_take), .cnt_inc(cnt_inc), .cnt_clr(cnt_clr),
        .ptr_clr(ptr_clr), .trig_pulse(trig_pulse), .end_pulse(end_pulse)
    );

    capseq_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
        .limit(limit), .zero(cnt_zero), .last(cnt_last)
    );

    capseq_wptr #(.ADDR_W(ADDR_W), .BSH(BSH)) u_ptr (
        .clk(clk), .rst_n(rst_n), .clr(ptr_clr),
        .adv(samp_we || tag_we), .take(trig_take),
        .wptr(mem_addr), .trig_baddr(trig_byte_addr)
    );

    // time stamps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_stamp <= '0;
            stop_stamp <= '0;
        end else begin
            if (trig_take) trig_stamp <= timestamp;
            if (stop_take) stop_stamp <= timestamp;
        end
    end

    generate
        if (TS_W == DATA_W) begin : g_tag_full
            assign tag_word = trig_stamp;
        end else begin : g_tag_ext
            assign tag_word = {{(DATA_W-TS_W){1'b0}}, trig_stamp};
        end
    endgenerate

    assign mem_we    = samp_we || tag_we;
    assign mem_wdata = tag_we ? tag_word : sample_data;
    assign busy      = (state != S_IDLE);

    // R9: memory is written only while busy
    a_r9_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R8: a stop leaves the block idle on the next cycle
    a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_take |=> !busy);
endmodule

// File: tb/test_capture_sequencer.sv
module test_capture_sequencer;
    localparam int DW = 32, AW = 5, CW = 12, TW = 32, DEPTH = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_code = 2'b00;
    logic [CW-1:0] pre_count = '0, post_count = '0;
    logic          sample_valid = 1'b0;
    logic [DW-1:0] sample_data = '0;
    logic          trigger_in = 1'b0;
    logic [TW-1:0] timestamp = '0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [AW+1:0] trig_byte_addr;
    logic [TW-1:0] trig_stamp, stop_stamp;
    logic          trig_pulse, end_pulse, busy;

    capture_sequencer i_capture_sequencer (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .pre_count(pre_count), .post_count(post_count),
        .sample_valid(sample_valid), .sample_data(sample_data),
        .trigger_in(trigger_in), .timestamp(timestamp),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .trig_byte_addr(trig_byte_addr), .trig_stamp(trig_stamp),
        .stop_stamp(stop_stamp), .trig_pulse(trig_pulse),
        .end_pulse(end_pulse), .busy(busy)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0;
    int q_addr[$];
    logic [DW-1:0] q_data[$];
    logic [TW-1:0] ts_r = '0;
    logic [DW-1:0] dseq = 32'hA000_0000;
    logic drv_busy = 0, drv_trig = 0, drv_end = 0;
    logic prev_trig = 0, prev_end = 0;
    logic mon_en = 0;
    int   ptr = 0;
    logic [AW+1:0] exp_taddr = '0;
    logic [TW-1:0] exp_tts = '0, exp_sts = '0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [DW-1:0] d);
        q_addr.push_back(ptr % DEPTH);
        q_data.push_back(d);
        ptr++;
    endtask

    function automatic logic [DW-1:0] nd();
        dseq = dseq + 1;
        return dseq;
    endfunction

    // one cycle of stimulus; eb = busy expected this cycle,
    // et/ee = trigger accepted / tag written this cycle (pulse expected next cycle)
    task automatic cyc(input logic sv, input logic [DW-1:0] d, input logic tr,
                       input logic [1:0] cmd, input logic eb, input logic et, input logic ee);
        @(posedge clk); #1;
        sample_valid = sv; sample_data = d; trigger_in = tr;
        cmd_valid = (cmd != 2'b00); cmd_code = cmd;
        ts_r = ts_r + 1; timestamp = ts_r;
        drv_busy = eb; drv_trig = et; drv_end = ee;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (mon_en) begin
            chk("R9 busy", busy, drv_busy);
            chk("R4 trig_pulse", trig_pulse, prev_trig);
            chk("R6 end_pulse", end_pulse, prev_end);
            prev_trig = drv_trig;
            prev_end  = drv_end;
            if (mem_we) begin
                if (q_addr.size() == 0) begin
                    chk("R9 unexpected write", {32'd0, mem_wdata}, 64'hDEAD);
                end else begin
                    chk("R2 write addr", mem_addr, q_addr.pop_front());
                    chk("R6 write data", mem_wdata, q_data.pop_front());
                end
            end
        end
    end

    task automatic acq(input int pre, input int post, input int nwait);
        logic [DW-1:0] d;
        pre_count = CW'(pre); post_count = CW'(post);
        cyc(1'b0, '0, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0);     // start (IDLE)
        ptr = 0;
        if (pre == 0) begin
            cyc(1'b1, nd(), 1'b1, 2'b00, 1'b1, 1'b0, 1'b0); // R10: no write
        end else begin
            for (int i = 0; i < pre; i++) begin
                if (i == 1) cyc(1'b0, '0, 1'b1, 2'b01, 1'b1, 1'b0, 1'b0); // R9 start ignored, R3
                d = nd(); push(d);
                cyc(1'b1, d, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0);  // R3 trigger ignored
            end
        end
        for (int i = 0; i < nwait; i++) begin
            d = nd(); push(d);
            cyc(1'b1, d, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0);
        end
        exp_taddr = (AW+2)'((ptr % DEPTH) * 4);
        d = nd(); push(d);
        cyc(1'b1, d, 1'b1, 2'b00, 1'b1, 1'b1, 1'b0);       // R4 trigger accepted
        exp_tts = ts_r;
        if (post == 0) begin
            cyc(1'b1, nd(), 1'b0, 2'b00, 1'b1, 1'b0, 1'b0); // R10: no write
        end else begin
            for (int i = 0; i < post; i++) begin
                if (i == 1) cyc(1'b0, '0, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0);
                d = nd(); push(d);
                cyc(1'b1, d, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0);
            end
        end
        push(DW'(exp_tts));
        cyc(1'b1, nd(), 1'b0, 2'b00, 1'b1, 1'b0, 1'b1);    // R6 tag word
        cyc(1'b0, '0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, '0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        chk("R5 trig_byte_addr", trig_byte_addr, exp_taddr);
        chk("R4 trig_stamp", trig_stamp, exp_tts);
        chk("R6 queue drained", q_addr.size(), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 mem_we", mem_we, 0);
        chk("R1 trig_byte_addr", trig_byte_addr, 0);
        chk("R1 stamps", {trig_stamp, stop_stamp}, 0);
        chk("R1 pulses", {trig_pulse, end_pulse}, 0);
        mon_en = 1;
        // R1: idle ignores samples, triggers and the reserved code
        for (int i = 0; i < 4; i++) cyc(1'b1, nd(), 1'b1, 2'b11, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, '0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        // R2 R3 R4 R5 R6 basic capture
        acq(4, 3, 2);
        chk("R8 stop_stamp unchanged", stop_stamp, 0);
        // R7 wrap, R2 restart at zero
        acq(20, 5, 14);
        chk("R7 wrapped trigger addr", trig_byte_addr, 7'd8);
        // R10 zero counts
        acq(0, 0, 1);
        // R8 stop colliding with trigger in WAIT_TRIG
        pre_count = 12'd2; post_count = 12'd4;
        cyc(1'b0, '0, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0);
        ptr = 0;
        for (int i = 0; i < 3; i++) begin
            d = nd(); push(d);
            cyc(1'b1, d, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0);
        end
        cyc(1'b1, nd(), 1'b1, 2'b10, 1'b1, 1'b0, 1'b0);
        exp_sts = ts_r;
        cyc(1'b1, nd(), 1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, '0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        chk("R8 stop_stamp", stop_stamp, exp_sts);
        chk("R8 trig addr kept", trig_byte_addr, exp_taddr);
        // R8 stop during POST_TRIG: no tag, no end pulse
        pre_count = 12'd1; post_count = 12'd5;
        cyc(1'b0, '0, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0);
        ptr = 0;
        d = nd(); push(d);
        cyc(1'b1, d, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0);
        exp_taddr = 7'd4;
        d = nd(); push(d);
        cyc(1'b1, d, 1'b1, 2'b00, 1'b1, 1'b1, 1'b0);
        d = nd(); push(d);
        cyc(1'b1, d, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0);
        cyc(1'b1, nd(), 1'b0, 2'b10, 1'b1, 1'b0, 1'b0);
        exp_sts = ts_r;
        cyc(1'b0, '0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, '0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        chk("R8 stop_stamp post", stop_stamp, exp_sts);
        chk("R5 trig addr post", trig_byte_addr, exp_taddr);
        chk("R8 queue drained", q_addr.size(), 0);
        mon_en = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule